// File: doc/BRIEF.md
# JTAG TAP Bus Monitor

The monitor watches the four signal lines of an IEEE 1149.1 test access port (test clock, mode select, data in, data out) without ever driving them. It oversamples those pins on a fast system clock, finds each rising edge of the test clock, and steps a local copy of the 16-state TAP controller with the mode-select value seen at that edge. Each step raises a one-cycle strobe that carries the new state code.

While the tracked controller stays in Shift-DR or Shift-IR across an edge, the monitor stores the data-in and data-out bits present at that edge. The first stored bit lands in bit 0. When the controller leaves a Shift state for the matching Exit1 state, a one-cycle result strobe presents both words, the bit count, an IR/DR flag and an overflow flag. The results hold their values until the next scan ends. A debug fabric or trace unit uses this to log scan traffic on a board-level test port.

Top module: `tap_monitor`

## Requirements
- R1: After reset, state_code_o is 1 (Run-Test/Idle), both strobes are low, and scan_len_o is 0.
- R2: The state codes are 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR and 15 Update-IR. With mode select 1/0, the transitions are: Test-Logic-Reset goes to itself/Run-Test/Idle; Run-Test/Idle goes to Select-DR/itself; Select-DR goes to Select-IR/Capture-DR; Select-IR goes to Test-Logic-Reset/Capture-IR.
- R3: Within each DR and IR group, with mode select 1/0, the transitions are: Capture goes to Exit1/Shift; Shift goes to Exit1/itself; Exit1 goes to Update/Pause; Pause goes to Exit2/itself; Exit2 goes to Update/Shift; Update goes to Select-DR/Run-Test/Idle.
- R4: Falling test-clock edges do not change the state, and neither do changes on mode select, data in or data out while the test clock is steady.
- R5: Each rising test-clock edge gives exactly one state_valid_o pulse, one system clock long. state_code_o changes only in a cycle where that pulse is high.
- R6: A bit pair is stored only on an edge where the state before and after the edge is the same Shift state. The first stored bit becomes bit 0 of the result.
- R7: On a Shift to Exit1 transition, scan_valid_o pulses for one cycle, together with state_valid_o. In that cycle scan_tdi_o, scan_tdo_o and scan_len_o are valid, and scan_is_ir_o is 1 for an IR scan and 0 for a DR scan. The scan outputs do not change at any other time.
- R8: Entering a Shift state from Capture or from Exit2 clears the stored bits and the count. A scan resumed after a pause reports only the bits shifted after the pause.
- R9: The count saturates at MAXBITS. If more bits arrive than fit, scan_overflow_o is 1 in the result, and the first MAXBITS bits are kept.
- R10: Result bits at positions at or above scan_len_o read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed test data in |
| tdo_i | input | 1 | Observed test data out |
| state_code_o | output | 4 | Tracked TAP state code |
| state_valid_o | output | 1 | One-cycle strobe on each state step |
| scan_tdi_o | output | MAXBITS | Captured data-in word, first bit at bit 0 |
| scan_tdo_o | output | MAXBITS | Captured data-out word, first bit at bit 0 |
| scan_len_o | output | $clog2(MAXBITS+1) | Number of bits captured |
| scan_is_ir_o | output | 1 | 1 for an IR scan, 0 for a DR scan |
| scan_overflow_o | output | 1 | More bits arrived than MAXBITS |
| scan_valid_o | output | 1 | One-cycle strobe at the end of a scan |

## Verification
The bench builds the monitor with MAXBITS set to 8 and keeps the default two synchronizer stages. With 8 bits, a scan of 10 bits saturates the count and sets the overflow flag, and a scan of exactly 8 bits fills the word without overflow, all within a few dozen test-clock periods. The other scans exercised are an empty scan (Capture, Shift, Exit1 with no stored bit), DR and IR scans of odd lengths, and a scan resumed after a pause.

// File: rtl/tap_mon_pkg.sv
package tap_mon_pkg;

  typedef enum logic [3:0] {
    TS_RESET  = 4'd0,
    TS_IDLE   = 4'd1,
    TS_SEL_DR = 4'd2,
    TS_CAP_DR = 4'd3,
    TS_SHF_DR = 4'd4,
    TS_EX1_DR = 4'd5,
    TS_PAU_DR = 4'd6,
    TS_EX2_DR = 4'd7,
    TS_UPD_DR = 4'd8,
    TS_SEL_IR = 4'd9,
    TS_CAP_IR = 4'd10,
    TS_SHF_IR = 4'd11,
    TS_EX1_IR = 4'd12,
    TS_PAU_IR = 4'd13,
    TS_EX2_IR = 4'd14,
    TS_UPD_IR = 4'd15
  } tap_state_e;

  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
    logic tdo;
  } pin_set_t;

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    unique case (s)
      TS_RESET:  return tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return tms ? TS_UPD_IR : TS_SHF_IR;
      default:   return tms ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

  function automatic logic is_shift(tap_state_e s);
    return (s == TS_SHF_DR) || (s == TS_SHF_IR);
  endfunction

endpackage

// File: rtl/tap_pin_sync.sv
module tap_pin_sync
  import tap_mon_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_set_t pins_i,
  output pin_set_t pins_o,
  output logic     tck_rise_o
);
  localparam int PW = $bits(pin_set_t);

  logic [STAGES-1:0][PW-1:0] chain_q;
  logic                      tck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q    <= '0;
      tck_prev_q <= 1'b0;
    end else begin
      chain_q[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      tck_prev_q <= pins_o.tck;
    end
  end

  assign pins_o     = pin_set_t'(chain_q[STAGES-1]);
  assign tck_rise_o = pins_o.tck & ~tck_prev_q;

endmodule

// File: rtl/tap_state_tracker.sv
module tap_state_tracker
  import tap_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       tms_i,
  output tap_state_e state_o,
  output tap_state_e next_o,
  output logic       valid_o
);
  tap_state_e state_q;
  logic       valid_q;

  assign next_o = tap_next(state_q, tms_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_i;
      if (step_i) state_q <= next_o;
    end
  end

  assign state_o = state_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tap_scan_capture.sv
module tap_scan_capture
  import tap_mon_pkg::*;
#(
  parameter int MAXBITS = 64,
  parameter int LEN_W   = $clog2(MAXBITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  tap_state_e         cur_i,
  input  tap_state_e         nxt_i,
  input  logic               tdi_i,
  input  logic               tdo_i,
  output logic [MAXBITS-1:0] tdi_o,
  output logic [MAXBITS-1:0] tdo_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               is_ir_o,
  output logic               ovf_o,
  output logic               valid_o
);
  localparam int IDX_W = (MAXBITS > 1) ? $clog2(MAXBITS) : 1;
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MAXBITS);

  logic [MAXBITS-1:0] acc_tdi_q, acc_tdo_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               ovf_q;
  logic               restart, take, finish, room;

  assign restart = step_i && is_shift(nxt_i) &&
                   (cur_i == TS_CAP_DR || cur_i == TS_CAP_IR ||
                    cur_i == TS_EX2_DR || cur_i == TS_EX2_IR);
  assign take    = step_i && is_shift(cur_i) && (nxt_i == cur_i);
  assign finish  = step_i && is_shift(cur_i) &&
                   (nxt_i == TS_EX1_DR || nxt_i == TS_EX1_IR);
  assign room    = cnt_q < FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_tdi_q <= '0;
      acc_tdo_q <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
    end else if (restart) begin
      acc_tdi_q <= '0;
      acc_tdo_q <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
    end else if (take) begin
      if (room) begin
        acc_tdi_q[cnt_q[IDX_W-1:0]] <= tdi_i;
        acc_tdo_q[cnt_q[IDX_W-1:0]] <= tdo_i;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdi_o   <= '0;
      tdo_o   <= '0;
      len_o   <= '0;
      is_ir_o <= 1'b0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= finish;
      if (finish) begin
        tdi_o   <= acc_tdi_q;
        tdo_o   <= acc_tdo_q;
        len_o   <= cnt_q;
        is_ir_o <= (cur_i == TS_SHF_IR);
        ovf_o   <= ovf_q;
      end
    end
  end

endmodule

// File: rtl/tap_monitor.sv
module tap_monitor
  import tap_mon_pkg::*;
#(
  parameter int MAXBITS     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAXBITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tck_i,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic               tdo_i,
  output logic [3:0]         state_code_o,
  output logic               state_valid_o,
  output logic [MAXBITS-1:0] scan_tdi_o,
  output logic [MAXBITS-1:0] scan_tdo_o,
  output logic [LEN_W-1:0]   scan_len_o,
  output logic               scan_is_ir_o,
  output logic               scan_overflow_o,
  output logic               scan_valid_o
);
  pin_set_t   pins_raw, pins_s;
  logic       tck_rise;
  tap_state_e cur_st, nxt_st;

  assign pins_raw = '{tck: tck_i, tms: tms_i, tdi: tdi_i, tdo: tdo_i};

  tap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_i     (pins_raw),
    .pins_o     (pins_s),
    .tck_rise_o (tck_rise)
  );

  tap_state_tracker u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tck_rise),
    .tms_i   (pins_s.tms),
    .state_o (cur_st),
    .next_o  (nxt_st),
    .valid_o (state_valid_o)
  );

  tap_scan_capture #(.MAXBITS(MAXBITS), .LEN_W(LEN_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tck_rise),
    .cur_i   (cur_st),
    .nxt_i   (nxt_st),
    .tdi_i   (pins_s.tdi),
    .tdo_i   (pins_s.tdo),
    .tdi_o   (scan_tdi_o),
    .tdo_o   (scan_tdo_o),
    .len_o   (scan_len_o),
    .is_ir_o (scan_is_ir_o),
    .ovf_o   (scan_overflow_o),
    .valid_o (scan_valid_o)
  );

  assign state_code_o = cur_st;

endmodule

// File: rtl/tap_monitor_chk.sv
module tap_monitor_chk #(
  parameter int MAXBITS = 64,
  parameter int LEN_W   = $clog2(MAXBITS + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         state_code_o,
  input logic               state_valid_o,
  input logic [MAXBITS-1:0] scan_tdi_o,
  input logic [MAXBITS-1:0] scan_tdo_o,
  input logic [LEN_W-1:0]   scan_len_o,
  input logic               scan_is_ir_o,
  input logic               scan_overflow_o,
  input logic               scan_valid_o
);
  assert_code_moves_on_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_code_o) |-> state_valid_o);

  assert_strobe_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_valid_o |=> !state_valid_o);

  assert_scan_at_exit1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_valid_o |-> state_valid_o && (state_code_o == 4'd5 || state_code_o == 4'd12)
                     && (scan_is_ir_o == (state_code_o == 4'd12)));

  assert_scan_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_valid_o |-> $stable(scan_tdi_o) && $stable(scan_tdo_o) && $stable(scan_len_o));

  assert_len_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_len_o <= LEN_W'(MAXBITS));

  assert_no_overflow_short_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_valid_o && scan_overflow_o |-> scan_len_o == LEN_W'(MAXBITS));

endmodule

bind tap_monitor tap_monitor_chk #(.MAXBITS(MAXBITS), .LEN_W(LEN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .state_code_o    (state_code_o),
  .state_valid_o   (state_valid_o),
  .scan_tdi_o      (scan_tdi_o),
  .scan_tdo_o      (scan_tdo_o),
  .scan_len_o      (scan_len_o),
  .scan_is_ir_o    (scan_is_ir_o),
  .scan_overflow_o (scan_overflow_o),
  .scan_valid_o    (scan_valid_o)
);

// File: tb/tap_monitor_test.sv
module tap_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 8;
  localparam int LW         = $clog2(MAXB + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tck_i = 1'b0, tms_i = 1'b0, tdi_i = 1'b0, tdo_i = 1'b0;
  logic [3:0]      state_code_o;
  logic            state_valid_o, scan_is_ir_o, scan_overflow_o, scan_valid_o;
  logic [MAXB-1:0] scan_tdi_o, scan_tdo_o;
  logic [LW-1:0]   scan_len_o;

  int checks = 0, fails = 0;
  logic [3:0] model = 4'd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_monitor #(.MAXBITS(MAXB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i), .tdo_i(tdo_i),
    .state_code_o(state_code_o), .state_valid_o(state_valid_o),
    .scan_tdi_o(scan_tdi_o), .scan_tdo_o(scan_tdo_o), .scan_len_o(scan_len_o),
    .scan_is_ir_o(scan_is_ir_o), .scan_overflow_o(scan_overflow_o), .scan_valid_o(scan_valid_o)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_next(logic [3:0] s, logic m);
    case (s)
      4'd0:  return m ? 4'd0 : 4'd1;
      4'd1:  return m ? 4'd2 : 4'd1;
      4'd2:  return m ? 4'd9 : 4'd3;
      4'd9:  return m ? 4'd0 : 4'd10;
      4'd3, 4'd4:   return m ? 4'd5 : 4'd4;
      4'd5:  return m ? 4'd8 : 4'd6;
      4'd6:  return m ? 4'd7 : 4'd6;
      4'd7:  return m ? 4'd8 : 4'd4;
      4'd10, 4'd11: return m ? 4'd12 : 4'd11;
      4'd12: return m ? 4'd15 : 4'd13;
      4'd13: return m ? 4'd14 : 4'd13;
      4'd14: return m ? 4'd15 : 4'd11;
      default: return m ? 4'd2 : 4'd1;
    endcase
  endfunction

  // One test-clock period; checks state step, strobe and quiet falling edge.
  task automatic step(input logic m, input logic di, input logic dout, input logic exp_scan, input string req);
    int bad;
    @(negedge clk);
    tms_i = m; tdi_i = di; tdo_i = dout;
    repeat (3) @(negedge clk);
    tck_i = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    model = ref_next(model, m);
    check(state_code_o == model, req, 64'(state_code_o), 64'(model));
    check(state_valid_o == 1'b1, "R5 strobe", 64'(state_valid_o), 64'd1);
    check(scan_valid_o == exp_scan, "R7 scan strobe", 64'(scan_valid_o), 64'(exp_scan));
    @(negedge clk);
    tck_i = 1'b0;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (state_valid_o || scan_valid_o || state_code_o != model) bad++;
    end
    check(bad == 0, "R4 falling edge quiet", 64'(bad), 64'd0);
  endtask

  task automatic test_reset();
    check(state_code_o == 4'd1, "R1 state", 64'(state_code_o), 64'd1);
    check(!state_valid_o && !scan_valid_o, "R1 strobes", 64'({state_valid_o, scan_valid_o}), 64'd0);
    check(scan_len_o == '0, "R1 len", 64'(scan_len_o), 64'd0);
  endtask

  task automatic test_walk_r2();
    step(0, 0, 0, 0, "R2 idle hold");
    step(1, 0, 0, 0, "R2 idle to sel_dr");
    step(1, 0, 0, 0, "R2 sel_dr to sel_ir");
    step(1, 0, 0, 0, "R2 sel_ir to reset");
    step(1, 0, 0, 0, "R2 reset hold");
    step(0, 0, 0, 0, "R2 reset to idle");
    step(1, 0, 0, 0, "R2 idle to sel_dr");
    step(1, 0, 0, 0, "R2 sel_dr to sel_ir");
    step(0, 0, 0, 0, "R2 sel_ir to cap_ir");
    step(1, 0, 0, 0, "R3 cap_ir to ex1_ir");
    step(0, 0, 0, 0, "R3 ex1 to pause");
    step(1, 0, 0, 0, "R3 pause to ex2");
    step(1, 0, 0, 0, "R3 ex2 to upd");
    step(1, 0, 0, 0, "R3 upd to sel_dr");
    step(0, 0, 0, 0, "R3 sel_dr to cap_dr");
    step(1, 0, 0, 0, "R3 cap_dr to ex1_dr");
    step(1, 0, 0, 0, "R3 ex1 to upd");
    step(0, 0, 0, 0, "R3 upd to idle");
  endtask

  task automatic test_pin_wiggle_r4();
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      tms_i = i[0]; tdi_i = i[1]; tdo_i = i[2];
      repeat (2) @(negedge clk);
      if (state_valid_o || state_code_o != model) bad++;
    end
    check(bad == 0, "R4 pins without edge", 64'(bad), 64'd0);
  endtask

  task automatic check_result(input logic ir, input int n, input logic [63:0] di, input logic [63:0] dout);
    int kept;
    logic [63:0] mask;
    kept = (n > MAXB) ? MAXB : n;
    mask = (kept >= 64) ? '1 : ((64'd1 << kept) - 1);
    check(64'(scan_len_o) == 64'(kept), "R9 len", 64'(scan_len_o), 64'(kept));
    check(scan_overflow_o == (n > MAXB), "R9 overflow", 64'(scan_overflow_o), 64'(n > MAXB));
    check(scan_is_ir_o == ir, "R7 ir flag", 64'(scan_is_ir_o), 64'(ir));
    check(64'(scan_tdi_o) == (di & mask), "R6 R10 tdi word", 64'(scan_tdi_o), di & mask);
    check(64'(scan_tdo_o) == (dout & mask), "R6 tdo word", 64'(scan_tdo_o), dout & mask);
  endtask

  task automatic scan(input logic ir, input int n, input logic [63:0] di, input logic [63:0] dout);
    step(1, 0, 0, 0, "R2 to sel_dr");
    if (ir) step(1, 0, 0, 0, "R2 to sel_ir");
    step(0, 0, 0, 0, "R2 to capture");
    step(0, 1, 1, 0, "R3 capture to shift");
    for (int i = 0; i < n; i++) step(0, di[i], dout[i], 0, "R6 shift bit");
    step(1, ~di[n], ~dout[n], 1, "R7 shift to exit1");
    check_result(ir, n, di, dout);
    step(1, 0, 0, 0, "R3 exit1 to update");
    step(0, 0, 0, 0, "R3 update to idle");
  endtask

  task automatic test_pause_r8();
    step(1, 0, 0, 0, "R2 to sel_dr");
    step(0, 0, 0, 0, "R2 to cap_dr");
    step(0, 0, 0, 0, "R3 to shift");
    step(0, 1, 0, 0, "R6 bit"); step(0, 1, 1, 0, "R6 bit"); step(0, 0, 1, 0, "R6 bit");
    step(1, 0, 0, 1, "R7 to exit1");
    check_result(0, 3, 64'b011, 64'b110);
    step(0, 0, 0, 0, "R3 to pause");
    step(0, 1, 1, 0, "R3 pause hold");
    step(1, 0, 0, 0, "R3 to exit2");
    step(0, 1, 1, 0, "R8 exit2 to shift");
    step(0, 0, 1, 0, "R6 bit"); step(0, 1, 0, 0, "R6 bit");
    step(1, 1, 1, 1, "R8 resumed exit1");
    check_result(0, 2, 64'b10, 64'b01);
    step(1, 0, 0, 0, "R3 to update");
    step(0, 0, 0, 0, "R3 to idle");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_walk_r2();
    test_pin_wiggle_r4();
    scan(0, 5, 64'h16, 64'h09);
    scan(1, 3, 64'h5, 64'h2);
    scan(0, 0, 64'h0, 64'h0);
    scan(1, MAXB, 64'hA5, 64'h3C);
    scan(0, MAXB + 2, 64'h2C3, 64'h15A);
    test_pause_r8();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule